// File: doc/BRIEF.md
# Embedded Controller Host Port

This block lets a host reach a 256-byte register space inside an embedded controller through only two byte-wide I/O locations. One is a data port. The other returns a status byte when read and takes a command byte when written. Every byte the host writes goes into a single input buffer. A small sequencer consumes that byte a fixed number of cycles later. The host learns the progress of each transfer from two flags: input-buffer-full and output-buffer-full.

To read a register, the host issues the read command and then writes the register address to the data port. When the result is ready, the output-buffer-full flag rises and the host reads the byte from the data port. To write a register, the host issues the write command and then writes the address and the value to the data port, in that order. Before writing any byte, the host waits for input-buffer-full to be clear. Before reading a result, it waits for output-buffer-full to be set. Two further commands turn a burst-mode flag on and off. A query command returns a zero event code.

Top module: `ec_host_port`

## Requirements
- R1: After reset, the status byte reads 0x00 and the data port reads 0x00.
- R2: A host write to either port sets status bit 1 (input full) from the next cycle on. The bit stays set for exactly `LAT` cycles and clears on the `LAT`-th clock edge after the write.
- R3: Status bit 3 is 1 while the pending byte was written to the command port (`host_sel`=1). It is 0 while the pending byte was written to the data port.
- R4: Command 0x80 followed by an address byte places the addressed register in the data port. Status bit 0 (output full) is set on the same edge that clears input full.
- R5: Command 0x81 followed by an address byte and then a value byte stores the value at that address.
- R6: A host read of the data port (`host_rd`=1, `host_sel`=0) clears output full from the next cycle on.
- R7: Command 0x82 sets status bit 4 (burst). Command 0x83 clears it.
- R8: Command 0x84 places 0x00 in the data port and sets output full.
- R9: A command byte that arrives in the middle of a sequence abandons that sequence. Decoding restarts from the new command, and no register is written.
- R10: An unknown command is consumed without effect. It does not set output full, it does not change burst, and it does not turn the next data byte into an address or a value.
- R11: A data byte that arrives while no command sequence is open is consumed and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 0 selects the data port, 1 selects the status/command port |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe. A data-port read consumes the output byte |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Data-port byte, or the status byte when `host_sel`=1 |

## Verification
Input full goes high one edge after a write strobe. It falls, and any output-full result rises, on the `LAT`-th edge after the write. Output full falls one edge after a data-port read. The bench drives each strobe for one cycle. For timing checks it samples the combinational read path on the falling edge right after the write, after `LAT-1` more cycles and after `LAT` more cycles, so that each flag is observed in the exact cycle it is due. The main sweep writes and then reads back all 256 addresses with an arithmetic pattern. Directed sequences cover the abort, unknown-command, stray-data, burst and query cases, and each of those checks its result through the status byte and by reading back the affected register.

// File: rtl/ec_host_port.sv
module ec_host_port #(
  parameter int LAT = 2,
  parameter int AW  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(LAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_RADDR, S_WADDR, S_WDATA} st_t;

  st_t           st;
  logic          ibf, obf, cmd_pend, burst;
  logic [7:0]    in_byte, out_byte;
  logic [CW-1:0] cnt;
  logic [AW-1:0] waddr;
  logic [7:0]    mem [DEPTH];

  wire take = ibf && (cnt == CW'(1));
  wire [7:0] status = {3'b000, burst, cmd_pend, 1'b0, ibf, obf};

  assign host_rdata = host_sel ? status : out_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ibf      <= 1'b0;
      obf      <= 1'b0;
      cmd_pend <= 1'b0;
      burst    <= 1'b0;
      in_byte  <= '0;
      out_byte <= '0;
      cnt      <= '0;
      waddr    <= '0;
    end else begin
      if (host_rd && !host_sel) obf <= 1'b0;
      if (host_wr) begin
        ibf      <= 1'b1;
        cnt      <= CW'(LAT);
        in_byte  <= host_wdata;
        cmd_pend <= host_sel;
      end else if (take) begin
        ibf      <= 1'b0;
        cmd_pend <= 1'b0;
        cnt      <= '0;
        if (cmd_pend) begin
          st <= S_IDLE;
          case (in_byte)
            8'h80: st <= S_RADDR;
            8'h81: st <= S_WADDR;
            8'h82: burst <= 1'b1;
            8'h83: burst <= 1'b0;
            8'h84: begin
              out_byte <= 8'h00;
              obf      <= 1'b1;
            end
            default: ;
          endcase
        end else begin
          case (st)
            S_RADDR: begin
              out_byte <= mem[in_byte[AW-1:0]];
              obf      <= 1'b1;
              st       <= S_IDLE;
            end
            S_WADDR: begin
              waddr <= in_byte[AW-1:0];
              st    <= S_WDATA;
            end
            S_WDATA: st <= S_IDLE;
            default: ;
          endcase
        end
      end else if (ibf) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && take && !cmd_pend && st == S_WDATA)
      mem[waddr] <= in_byte;
  end

  // R2
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> ibf);

  // R6
  obf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_sel && !ibf) |=> !obf);

  // R4
  obf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obf) |-> $fell(ibf));

  // R7
  burst_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(burst) |-> $fell(ibf));

  // R3
  cmd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pend |-> ibf);
endmodule

// File: tb/test_ec_host_port.sv
module test_ec_host_port;
  localparam int LAT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_sel = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  ec_host_port #(.LAT(LAT), .AW(8)) i_ec_host_port (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic strobe(bit sel, logic [7:0] b);
    @(negedge clk);
    host_sel = sel; host_wr = 1'b1; host_wdata = b;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic put(bit sel, logic [7:0] b);
    strobe(sel, b);
    repeat (LAT) @(negedge clk);
  endtask

  task automatic status(output logic [7:0] s);
    host_sel = 1'b1;
    #1 s = host_rdata;
  endtask

  task automatic get_data(output logic [7:0] d);
    host_sel = 1'b0; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic reg_write(logic [7:0] a, logic [7:0] v);
    put(1, 8'h81); put(0, a); put(0, v);
  endtask

  task automatic reg_read(logic [7:0] a, output logic [7:0] d, output logic [7:0] s);
    put(1, 8'h80); put(0, a);
    status(s);
    get_data(d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    status(s); check("R1 status", s, 8'h00);
    host_sel = 1'b0; #1 check("R1 data", host_rdata, 8'h00);

    // R2 R3 R11: stray data byte, timing of input full
    strobe(0, 8'h55);
    status(s); check("R2/R3 pending data", s, 8'h02);
    repeat (LAT - 1) @(negedge clk);
    status(s); check("R2 still full", s, 8'h02);
    @(negedge clk);
    status(s); check("R2/R11 consumed", s, 8'h00);

    // R5 R4 R6 sweep
    for (int a = 0; a < 256; a++) reg_write(8'(a), pat(a));
    for (int a = 0; a < 256; a++) begin
      reg_read(8'(a), d, s);
      check("R4 obf set", s, 8'h01);
      check("R5 readback", d, pat(a));
      @(negedge clk);
      status(s); check("R6 obf clear", s, 8'h00);
    end

    // R3 R10: unknown command
    strobe(1, 8'h99);
    status(s); check("R3 pending cmd", s, 8'h0A);
    repeat (LAT) @(negedge clk);
    status(s); check("R10 no effect", s, 8'h00);
    put(0, 8'h10); put(0, 8'h20);
    status(s); check("R10 data ignored", s, 8'h00);
    reg_read(8'h10, d, s);
    check("R10 reg untouched", d, pat(16));
    reg_read(8'h20, d, s);
    check("R10 reg2 untouched", d, pat(32));

    // R7 burst
    put(1, 8'h82);
    status(s); check("R7 burst on", s, 8'h10);
    put(1, 8'h83);
    status(s); check("R7 burst off", s, 8'h00);

    // R8 query
    put(1, 8'h84);
    status(s); check("R8 obf", s, 8'h01);
    get_data(d); check("R8 data", d, 8'h00);

    // R9 abort write with a read
    put(1, 8'h81); put(0, 8'h40);
    reg_read(8'h40, d, s);
    check("R9 obf", s, 8'h01);
    check("R9 not written", d, pat(64));
    put(0, 8'h77);
    reg_read(8'h40, d, s);
    check("R9/R11 still intact", d, pat(64));

    // R9 abort read with a write
    put(1, 8'h80);
    reg_write(8'h05, 8'hEE);
    status(s); check("R9 no obf", s, 8'h00);
    reg_read(8'h05, d, s);
    check("R9 new write", d, 8'hEE);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule